// File: doc/BRIEF.md
# Self-Resetting Sparse Pulse Counter

This block divides a stream of sparse single-cycle pulses by a fixed ratio. The ratio is a parameter. Internally it keeps a chain of open gaps, one per pulse in the ratio. Each accepted pulse bridges the next open gap, but only after a settling delay. The pulse that bridges the last gap travels on to the output. Releasing that pulse reopens every gap, so the next output needs a full set of pulses again.

Pulses must be sparse. A pulse that comes too soon after the last accepted pulse is dropped, and a one-cycle spacing flag reports it. A separate clear input reopens every gap at any moment. It also cancels a pulse that is still settling. Clear takes precedence over a pulse that arrives in the same cycle.

Top module: `pulse_counter`

## Requirements
- R1: `pulseOut` is high for exactly one cycle, and only in the fifth cycle after the cycle in which the PULSES_PER_OUT-th accepted pulse was sampled. With defaults, an accepted pulse sampled in cycle t that completes a set gives `pulseOut` high in cycle t+5.
- R2: Once `pulseOut` has fired, the block has reopened every gap by itself, and the next `pulseOut` needs another PULSES_PER_OUT accepted pulses.
- R3: A pulse is accepted only if at least MIN_IDLE+1 (default 6) idle cycles separate it from the last accepted pulse. A pulse with exactly MIN_IDLE idle cycles is rejected. A rejected pulse does not restart this window.
- R4: A rejected pulse sets `spacingErr` high for one cycle, in the cycle after the pulse. It adds nothing to the count.
- R5: A cycle with `clearIn` high reopens every gap, whatever the count. A pulse that is still settling is discarded, so the next output needs a full PULSES_PER_OUT accepted pulses.
- R6: When `clearIn` and `pulseIn` are high in the same cycle, the pulse is discarded without a spacing flag and does not restart the spacing window.
- R7: When `clearIn` is high in the cycle in which `pulseOut` would fire, the output is suppressed.
- R8: While `rst_n` is low, and in the first cycle after it rises, both outputs are low and every gap is open. The first pulse after reset is accepted whatever its spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulseIn | input | 1 | Single-cycle input pulse |
| clearIn | input | 1 | Reopens all gaps; wins over `pulseIn` |
| pulseOut | output | 1 | One-cycle output pulse, once per completed set |
| spacingErr | output | 1 | One-cycle flag for a pulse that came too soon |

## Verification
The hardest cases to reach from the ports depend on exact cycle alignment. One is a clear that lands in the very cycle the output would fire. The other is a clear that lands while a pulse is still settling. The stimulus places each of these by choosing how many idle cycles come before the clear after a counted pulse: four idle cycles for the firing cycle, two for mid-settle. Whether a rejected pulse restarts the spacing window is probed by a chain of early pulses followed by one that is legal only when measured from the last accepted pulse.

// File: rtl/pulse_count_pkg.sv
package pulse_count_pkg;

  // Strobes from the control half to the gap chain.
  typedef struct packed {
    logic accept;  // pulse passed spacing and clear checks
    logic close;   // settling finished: the next gap is bridged now
    logic clear;   // reopen every gap
  } ctrlStrobe_t;

endpackage

// File: rtl/pulse_count_ctrl.sv
module pulse_count_ctrl
  import pulse_count_pkg::*;
#(
  parameter int MIN_IDLE   = 5,
  parameter int SETTLE_CYC = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pulseIn,
  input  logic        clearIn,
  output ctrlStrobe_t strobes,
  output logic        spacingErr
);

  localparam int GAP_W = $clog2(MIN_IDLE + 2);
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(MIN_IDLE + 1);
  localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SET_W-1:0] SET_LOAD = SET_W'(SETTLE_CYC - 1);

  logic [GAP_W-1:0] idleCnt;   // idle cycles since the last accepted pulse, saturating
  logic [SET_W-1:0] settleCnt;
  logic             busy;
  logic             spaced;
  logic             tooSoon;

  assign spaced  = (idleCnt == GAP_FULL);
  assign tooSoon = pulseIn && !clearIn && !spaced;

  assign strobes.accept = pulseIn && !clearIn && spaced;
  assign strobes.close  = busy && (settleCnt == '0) && !clearIn;
  assign strobes.clear  = clearIn;

  // Spacing window; the saturated value after reset lets the first pulse in.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= GAP_FULL;
    end else if (strobes.accept) begin
      idleCnt <= '0;
    end else if (!spaced) begin
      idleCnt <= idleCnt + GAP_W'(1);
    end
  end

  // One settling timer is enough: legal spacing exceeds the settle time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      settleCnt <= '0;
    end else if (clearIn) begin
      busy      <= 1'b0;
      settleCnt <= '0;
    end else if (strobes.accept) begin
      busy      <= 1'b1;
      settleCnt <= SET_LOAD;
    end else if (busy) begin
      if (settleCnt == '0) begin
        busy <= 1'b0;
      end else begin
        settleCnt <= settleCnt - SET_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spacingErr <= 1'b0;
    end else begin
      spacingErr <= tooSoon;
    end
  end

  // R3: two accepted pulses can never be adjacent
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.accept |=> !strobes.accept);

  // R4: the flag only follows a real, unclear pulse
  a_r4_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    spacingErr |-> ($past(pulseIn) && !$past(clearIn)));

  // R5: a clear cancels any settling pulse
  a_r5_clear_stops_settle: assert property (@(posedge clk) disable iff (!rst_n)
    clearIn |=> !busy);

  // R6: a pulse together with a clear never raises the flag
  a_r6_no_err_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clearIn |=> !spacingErr);

endmodule

// File: rtl/pulse_count_gaps.sv
module pulse_count_gaps
  import pulse_count_pkg::*;
#(
  parameter int NUM_GAPS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t strobes,
  output logic        pulseOut
);

  // The last gap never holds state: bridging it is the output pulse itself.
  localparam int STORE_W = NUM_GAPS - 1;

  logic [STORE_W-1:0] gapVec;  // thermometer of bridged gaps
  logic               fire;

  assign fire     = strobes.close && gapVec[STORE_W-1];
  assign pulseOut = fire;

  for (genvar i = 0; i < STORE_W; i++) begin : g_gap
    logic prevBridged;
    if (i == 0) begin : g_first
      assign prevBridged = 1'b1;
    end else begin : g_next
      assign prevBridged = gapVec[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gapVec[i] <= 1'b0;
      end else if (strobes.clear || fire) begin
        gapVec[i] <= 1'b0;
      end else if (strobes.close && prevBridged) begin
        gapVec[i] <= 1'b1;
      end
    end
  end

  // R1: the output is a single-cycle pulse
  a_r1_single_out: assert property (@(posedge clk) disable iff (!rst_n)
    pulseOut |=> !pulseOut);

  // R2: firing reopens all gaps
  a_r2_self_reset: assert property (@(posedge clk) disable iff (!rst_n)
    pulseOut |=> (gapVec == '0));

  // R5: a clear reopens all gaps
  a_r5_clear_reopens: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clear |=> (gapVec == '0));

  // R2: gaps are bridged strictly in order
  a_r2_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    ((gapVec & (gapVec + STORE_W'(1))) == '0));

endmodule

// File: rtl/pulse_counter.sv
module pulse_counter
  import pulse_count_pkg::*;
#(
  parameter int PULSES_PER_OUT = 4,
  parameter int MIN_IDLE       = 5,
  parameter int SETTLE_CYC     = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulseIn,
  input  logic clearIn,
  output logic pulseOut,
  output logic spacingErr
);

  ctrlStrobe_t strobes;

  pulse_count_ctrl #(
    .MIN_IDLE  (MIN_IDLE),
    .SETTLE_CYC(SETTLE_CYC)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulseIn   (pulseIn),
    .clearIn   (clearIn),
    .strobes   (strobes),
    .spacingErr(spacingErr)
  );

  pulse_count_gaps #(
    .NUM_GAPS(PULSES_PER_OUT)
  ) gaps_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .pulseOut(pulseOut)
  );

endmodule

// File: tb/pulse_counter_tb_top.sv
module pulse_counter_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulseIn = 1'b0;
  logic clearIn = 1'b0;
  logic pulseOut;
  logic spacingErr;

  int checkCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  int fireSeen = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  bit expOut [0:4095];
  bit expErr [0:4095];

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  pulse_counter dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulseIn   (pulseIn),
    .clearIn   (clearIn),
    .pulseOut  (pulseOut),
    .spacingErr(spacingErr)
  );

  // Entry: {idle cycles before, pulse, clear, expect flag next cycle, expect fire 5 cycles later}
  typedef logic [11:0] vec_t;
  localparam int NVEC = 38;
  localparam vec_t VEC [0:NVEC-1] = '{
    {8'd2, 4'b1000}, {8'd6, 4'b1000}, {8'd8, 4'b1000}, {8'd6, 4'b1001},  // R1 R3 exact-6 spacing
    {8'd6, 4'b1000}, {8'd2, 4'b1010}, {8'd1, 4'b1010}, {8'd5, 4'b1000},  // R4, window not restarted
    {8'd5, 4'b1010}, {8'd7, 4'b1000}, {8'd6, 4'b1001},                   // R3 boundary 5 rejected, R2
    {8'd6, 4'b1000}, {8'd6, 4'b1000}, {8'd6, 4'b0100},                   // R5 clear with 2 bridged
    {8'd6, 4'b1000}, {8'd6, 4'b1000}, {8'd6, 4'b1000}, {8'd6, 4'b1001},
    {8'd6, 4'b1000}, {8'd2, 4'b0100},                                    // R5 clear mid-settle
    {8'd6, 4'b1000}, {8'd6, 4'b1000}, {8'd6, 4'b1000}, {8'd6, 4'b1001},
    {8'd6, 4'b1100}, {8'd2, 4'b1000},                                    // R6 pulse with clear
    {8'd6, 4'b1000}, {8'd6, 4'b1000}, {8'd6, 4'b1001},
    {8'd6, 4'b1000}, {8'd6, 4'b1000}, {8'd6, 4'b1000}, {8'd6, 4'b1000},
    {8'd4, 4'b0100},                                                     // R7 clear in firing cycle
    {8'd6, 4'b1000}, {8'd6, 4'b1000}, {8'd6, 4'b1000}, {8'd6, 4'b1001}
  };

  task automatic drive(input logic p, input logic c);
    @(posedge clk);
    #2;
    pulseIn = p;
    clearIn = c;
  endtask

  task automatic doEntry(input int idle, input logic p, input logic c,
                         input logic eErr, input logic eFire);
    int at;
    for (int k = 0; k < idle; k++) drive(1'b0, 1'b0);
    drive(p, c);
    at = cyc;
    if (eErr) expErr[at + 1] = 1'b1;
    if (eFire) expOut[at + 5] = 1'b1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Outputs sampled at the falling edge, away from input changes.
  always @(negedge clk) begin
    if (checking) begin
      check(pulseOut == expOut[cyc], "R1 R2 R5 R7 pulseOut", int'(pulseOut), int'(expOut[cyc]));
      check(spacingErr == expErr[cyc], "R3 R4 R6 spacingErr", int'(spacingErr), int'(expErr[cyc]));
      if (pulseOut) fireSeen++;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL R1 watchdog: finished=0 expected=1");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      expOut[i] = 1'b0;
      expErr[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #2;
    // R8: outputs low while in reset
    check(pulseOut == 1'b0 && spacingErr == 1'b0, "R8 reset outputs",
          int'({pulseOut, spacingErr}), 0);
    rst_n = 1'b1;
    checking = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      doEntry(int'(VEC[v][11:4]), VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);
    end

    // R8: reset in mid-set, then an immediate pulse is accepted
    doEntry(6, 1'b1, 1'b0, 1'b0, 1'b0);
    doEntry(6, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 7; k++) drive(1'b0, 1'b0);
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    doEntry(0, 1'b1, 1'b0, 1'b0, 1'b0);
    doEntry(6, 1'b1, 1'b0, 1'b0, 1'b0);
    doEntry(6, 1'b1, 1'b0, 1'b0, 1'b0);
    doEntry(6, 1'b1, 1'b0, 1'b0, 1'b1);

    for (int k = 0; k < 10; k++) drive(1'b0, 1'b0);
    @(negedge clk);
    checking = 1'b0;
    // R2: total output count over the run
    check(fireSeen == 7, "R2 output count", fireSeen, 7);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule